// File: doc/BRIEF.md
# Hashed Direct-Mapped Instruction Translation Buffer

This block sits between the instruction fetch stage and the instruction cache. When the fetch unit runs with translation on, each fetch address is looked up in a direct-mapped table of recent translations. A hit yields the real address one cycle later. A miss, or a privileged page fetched from user mode, raises a fetch-failed flag so that the core can request a page-table walk or take a fault. With translation off, the address goes through unchanged and the fetch never fails.

The slot for an address is chosen by folding three adjacent page-number fields together with XOR. Translations come back from an external page-table walker and are written into the slot of the faulting address, replacing whatever that slot held. A walker result that would not allow execution in any context is never stored. Invalidation requests clear either the single slot an address hashes to, with no tag compare, or every slot.

The translation mode and the privilege mode are latched only on a fetch redirect. A mode change therefore takes effect at the next branch, return or context synchronisation.

Top module: `itlb_xlate`

## Requirements
- R1: After reset the mode is real and privileged, `out_valid_o` is 0, and every slot is empty, so a translated fetch issued before any install misses.
- R2: The slot index is the XOR of fetch-address bits [17:12], [23:18] and [29:24] (64 slots). Addresses whose fields XOR to the same value share one slot.
- R3: An accepted install writes the slot of `install_addr_i` with its tag (address bits above 11), and the previous occupant of that slot stops hitting.
- R4: One cycle after a translated fetch that hits, `real_addr_o` is the stored real page number (PTE bits [55:12]) joined with fetch-address bits [11:0]. At the same time `hit_o` is 1 and `fetch_fail_o` is 0 when the page is allowed.
- R5: An invalidate with a zero scope field and a zero page-size field clears the slot that `inval_addr_i` hashes to, whatever tag that slot holds.
- R6: Every slot is cleared by an invalidate with a nonzero scope field, by an invalidate with a nonzero page-size field, or by a segment-invalidate-all whose hint equals 7. A segment-invalidate-all with any other hint leaves the table unchanged.
- R7: A translated fetch that misses gives `hit_o` 0 and `fetch_fail_o` 1.
- R8: A translated fetch that hits a slot whose PTE bit 3 is set fails (`hit_o` 1, `fetch_fail_o` 1) when the fetch is not privileged, and succeeds when it is.
- R9: An install whose PTE has bit 0 (execute) clear or bit 8 (referenced) clear leaves the table unchanged.
- R10: The translate and privilege modes change only on a cycle with `redirect_i` high. The fetch presented in that same cycle already uses the new modes.
- R11: With translation off, a fetch gives `hit_o` 1, `fetch_fail_o` 0, and `real_addr_o` equal to fetch-address bits [55:0].
- R12: A cycle without `fetch_valid_i` gives `out_valid_o`, `hit_o` and `fetch_fail_o` all 0 in the following cycle.
- R13: An install presented in the same cycle as any invalidation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_i | input | 1 | Fetch redirect; latches the modes |
| redirect_virt_i | input | 1 | Translate mode carried by the redirect |
| redirect_priv_i | input | 1 | Privilege mode carried by the redirect |
| fetch_valid_i | input | 1 | Fetch address valid |
| fetch_addr_i | input | 64 | Effective fetch address |
| out_valid_o | output | 1 | Lookup result valid (one cycle after fetch) |
| hit_o | output | 1 | Translation found, or real mode |
| fetch_fail_o | output | 1 | Miss or privilege violation |
| real_addr_o | output | 56 | Real fetch address |
| install_i | input | 1 | Walker result valid |
| install_addr_i | input | 64 | Effective address the walk was done for |
| install_pte_i | input | 64 | Page table entry from the walker |
| inval_i | input | 1 | Translation invalidate request |
| inval_addr_i | input | 64 | Address selecting the slot for a single invalidate |
| inval_scope_i | input | 2 | Scope field; nonzero flushes all |
| inval_psize_i | input | 3 | Page-size field; nonzero flushes all |
| seginv_i | input | 1 | Segment-invalidate-all request |
| seginv_hint_i | input | 3 | Hint; value 7 flushes all |

## Verification
The bench builds the block with its default parameters: 64-bit effective addresses, 56-bit real addresses, 4 KiB pages and 64 slots. With these values the hash covers address bits 12 to 29. The bench therefore places aliasing addresses in each of the three fields, and also uses an address that differs only above bit 29, so that a slot shared by different tags can be shown through replacement and through untagged invalidation. The same configuration lets every flush trigger, the install filter and the same-cycle install-versus-invalidate case be observed through later fetch results.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

  localparam int PTE_W        = 64;
  localparam int PTE_EXEC_BIT = 0;
  localparam int PTE_PRIV_BIT = 3;
  localparam int PTE_REF_BIT  = 8;
  localparam logic [2:0] SEG_HINT_ALL = 3'd7;

  typedef enum logic [1:0] {
    INV_NONE = 2'd0,
    INV_ONE  = 2'd1,
    INV_ALL  = 2'd2
  } inv_kind_e;

endpackage

// File: rtl/itlb_hash.sv
module itlb_hash #(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 6,
  parameter int NFIELDS   = 3
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [IDX_BITS-1:0] idx_o
);

  logic [IDX_BITS-1:0] fold [NFIELDS+1];

  assign fold[0] = '0;

  for (genvar k = 0; k < NFIELDS; k++) begin : g_field
    assign fold[k+1] = fold[k] ^ addr_i[PAGE_BITS + k*IDX_BITS +: IDX_BITS];
  end

  assign idx_o = fold[NFIELDS];

endmodule

// File: rtl/itlb_inval_dec.sv
module itlb_inval_dec
  import itlb_pkg::*;
(
  input  logic       inval_i,
  input  logic [1:0] inval_scope_i,
  input  logic [2:0] inval_psize_i,
  input  logic       seginv_i,
  input  logic [2:0] seginv_hint_i,
  output inv_kind_e  kind_o
);

  logic wide_inval;
  logic seg_all;

  always_comb begin
    wide_inval = inval_i && ((inval_scope_i != 2'd0) || (inval_psize_i != 3'd0));
    seg_all    = seginv_i && (seginv_hint_i == SEG_HINT_ALL);
    if (wide_inval || seg_all) begin
      kind_o = INV_ALL;
    end else if (inval_i) begin
      kind_o = INV_ONE;
    end else begin
      kind_o = INV_NONE;
    end
  end

endmodule

// File: rtl/itlb_array.sv
module itlb_array #(
  parameter int IDX_BITS = 6,
  parameter int TAG_W    = 52,
  parameter int RPN_W    = 44,
  localparam int ENTRIES = 1 << IDX_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en_i,
  input  logic [IDX_BITS-1:0] wr_idx_i,
  input  logic [TAG_W-1:0]    wr_tag_i,
  input  logic [RPN_W-1:0]    wr_rpn_i,
  input  logic                wr_priv_i,
  input  logic                clr_one_i,
  input  logic [IDX_BITS-1:0] clr_idx_i,
  input  logic                clr_all_i,
  input  logic [IDX_BITS-1:0] rd_idx_i,
  output logic                rd_valid_o,
  output logic [TAG_W-1:0]    rd_tag_o,
  output logic [RPN_W-1:0]    rd_rpn_o,
  output logic                rd_priv_o,
  output logic [ENTRIES-1:0]  valid_vec_o
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [TAG_W-1:0]   tag_mem  [ENTRIES];
  logic [RPN_W-1:0]   rpn_mem  [ENTRIES];
  logic               priv_mem [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_comb begin
      if (clr_all_i) begin
        valid_d[i] = 1'b0;
      end else if (clr_one_i && (clr_idx_i == IDX_BITS'(i))) begin
        valid_d[i] = 1'b0;
      end else if (wr_en_i && (wr_idx_i == IDX_BITS'(i))) begin
        valid_d[i] = 1'b1;
      end else begin
        valid_d[i] = valid_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_mem[wr_idx_i]  <= wr_tag_i;
      rpn_mem[wr_idx_i]  <= wr_rpn_i;
      priv_mem[wr_idx_i] <= wr_priv_i;
    end
  end

  assign rd_valid_o  = valid_q[rd_idx_i];
  assign rd_tag_o    = tag_mem[rd_idx_i];
  assign rd_rpn_o    = rpn_mem[rd_idx_i];
  assign rd_priv_o   = priv_mem[rd_idx_i];
  assign valid_vec_o = valid_q;

endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
  import itlb_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int RA_W      = 56,
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 6,
  localparam int TAG_W    = ADDR_W - PAGE_BITS,
  localparam int RPN_W    = RA_W - PAGE_BITS,
  localparam int ENTRIES  = 1 << IDX_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redirect_i,
  input  logic              redirect_virt_i,
  input  logic              redirect_priv_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              out_valid_o,
  output logic              hit_o,
  output logic              fetch_fail_o,
  output logic [RA_W-1:0]   real_addr_o,
  input  logic              install_i,
  input  logic [ADDR_W-1:0] install_addr_i,
  input  logic [PTE_W-1:0]  install_pte_i,
  input  logic              inval_i,
  input  logic [ADDR_W-1:0] inval_addr_i,
  input  logic [1:0]        inval_scope_i,
  input  logic [2:0]        inval_psize_i,
  input  logic              seginv_i,
  input  logic [2:0]        seginv_hint_i
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  // slot selection for the three address sources
  logic [IDX_BITS-1:0] fetch_idx;
  logic [IDX_BITS-1:0] install_idx;
  logic [IDX_BITS-1:0] inval_idx;

  itlb_hash #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS), .NFIELDS(3))
    u_hash_fetch (.addr_i(fetch_addr_i), .idx_o(fetch_idx));
  itlb_hash #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS), .NFIELDS(3))
    u_hash_install (.addr_i(install_addr_i), .idx_o(install_idx));
  itlb_hash #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_BITS(IDX_BITS), .NFIELDS(3))
    u_hash_inval (.addr_i(inval_addr_i), .idx_o(inval_idx));

  // invalidation classification
  inv_kind_e inv_kind;

  itlb_inval_dec u_dec (
    .inval_i       (inval_i),
    .inval_scope_i (inval_scope_i),
    .inval_psize_i (inval_psize_i),
    .seginv_i      (seginv_i),
    .seginv_hint_i (seginv_hint_i),
    .kind_o        (inv_kind)
  );

  // install filtering: executable, referenced, no concurrent invalidation
  logic pte_usable;
  logic wr_en;

  always_comb begin
    pte_usable = install_pte_i[PTE_EXEC_BIT] && install_pte_i[PTE_REF_BIT];
    wr_en      = install_i && pte_usable && (inv_kind == INV_NONE);
  end

  // storage
  logic               rd_valid;
  logic [TAG_W-1:0]   rd_tag;
  logic [RPN_W-1:0]   rd_rpn;
  logic               rd_priv;
  logic [ENTRIES-1:0] valid_vec;

  itlb_array #(.IDX_BITS(IDX_BITS), .TAG_W(TAG_W), .RPN_W(RPN_W)) u_array (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .wr_en_i     (wr_en),
    .wr_idx_i    (install_idx),
    .wr_tag_i    (install_addr_i[ADDR_W-1:PAGE_BITS]),
    .wr_rpn_i    (install_pte_i[RA_W-1:PAGE_BITS]),
    .wr_priv_i   (install_pte_i[PTE_PRIV_BIT]),
    .clr_one_i   (inv_kind == INV_ONE),
    .clr_idx_i   (inval_idx),
    .clr_all_i   (inv_kind == INV_ALL),
    .rd_idx_i    (fetch_idx),
    .rd_valid_o  (rd_valid),
    .rd_tag_o    (rd_tag),
    .rd_rpn_o    (rd_rpn),
    .rd_priv_o   (rd_priv),
    .valid_vec_o (valid_vec)
  );

  // mode latches, updated only by a redirect
  logic virt_q, priv_q;
  logic virt_d, priv_d;

  always_comb begin
    virt_d = redirect_i ? redirect_virt_i : virt_q;
    priv_d = redirect_i ? redirect_priv_i : priv_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      virt_q <= 1'b0;
      priv_q <= 1'b1;
    end else if (redirect_i) begin
      virt_q <= virt_d;
      priv_q <= priv_d;
    end
  end

  // lookup result, next state
  logic            tag_match;
  logic            out_valid_d, hit_d, fail_d;
  logic [RA_W-1:0] ra_d;

  always_comb begin
    tag_match   = rd_valid && (rd_tag == fetch_addr_i[ADDR_W-1:PAGE_BITS]);
    out_valid_d = fetch_valid_i;
    hit_d       = 1'b0;
    fail_d      = 1'b0;
    ra_d        = fetch_addr_i[RA_W-1:0];
    if (fetch_valid_i) begin
      if (!virt_d) begin
        hit_d = 1'b1;
      end else begin
        hit_d  = tag_match;
        fail_d = !tag_match || (rd_priv && !priv_d);
        ra_d   = {rd_rpn, fetch_addr_i[PAGE_BITS-1:0]};
      end
    end
  end

  // lookup result, registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid_o  <= 1'b0;
      hit_o        <= 1'b0;
      fetch_fail_o <= 1'b0;
    end else begin
      out_valid_o  <= out_valid_d;
      hit_o        <= hit_d;
      fetch_fail_o <= fail_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fetch_valid_i) begin
      real_addr_o <= ra_d;
    end
  end

endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk
  import itlb_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int RA_W     = 56,
  parameter int IDX_BITS = 6,
  localparam int ENTRIES = 1 << IDX_BITS
) (
  input logic                clk,
  input logic                rst_q_n,
  input logic                redirect_i,
  input logic                redirect_virt_i,
  input logic                fetch_valid_i,
  input logic [ADDR_W-1:0]   fetch_addr_i,
  input logic                out_valid_o,
  input logic                hit_o,
  input logic                fetch_fail_o,
  input logic [RA_W-1:0]     real_addr_o,
  input logic                install_i,
  input logic [PTE_W-1:0]    install_pte_i,
  input inv_kind_e           inv_kind,
  input logic [IDX_BITS-1:0] inval_idx,
  input logic [ENTRIES-1:0]  valid_vec,
  input logic                virt_q
);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_q_n)
    !out_valid_o |-> (!hit_o && !fetch_fail_o));

  assert_miss_fails_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid_o && !hit_o) |-> fetch_fail_o);

  assert_real_pass_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fetch_valid_i && !(redirect_i ? redirect_virt_i : virt_q))
      |=> (hit_o && !fetch_fail_o && (real_addr_o == $past(fetch_addr_i[RA_W-1:0]))));

  assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (inv_kind == INV_ALL) |=> (valid_vec == '0));

  assert_inval_one_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (inv_kind == INV_ONE) |=> !valid_vec[$past(inval_idx)]);

  assert_install_filter_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (install_i && (inv_kind == INV_NONE) &&
     !(install_pte_i[PTE_EXEC_BIT] && install_pte_i[PTE_REF_BIT])) |=> $stable(valid_vec));

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !redirect_i |=> $stable(virt_q));

endmodule

bind itlb_xlate itlb_xlate_chk #(
  .ADDR_W   (ADDR_W),
  .RA_W     (RA_W),
  .IDX_BITS (IDX_BITS)
) u_chk (
  .clk             (clk),
  .rst_q_n         (rst_q_n),
  .redirect_i      (redirect_i),
  .redirect_virt_i (redirect_virt_i),
  .fetch_valid_i   (fetch_valid_i),
  .fetch_addr_i    (fetch_addr_i),
  .out_valid_o     (out_valid_o),
  .hit_o           (hit_o),
  .fetch_fail_o    (fetch_fail_o),
  .real_addr_o     (real_addr_o),
  .install_i       (install_i),
  .install_pte_i   (install_pte_i),
  .inv_kind        (inv_kind),
  .inval_idx       (inval_idx),
  .valid_vec       (valid_vec),
  .virt_q          (virt_q)
);

// File: tb/itlb_xlate_tb.sv
`timescale 1ns/1ps
module itlb_xlate_tb;

  logic        clk;
  logic        rst_n;
  logic        redirect_i, redirect_virt_i, redirect_priv_i;
  logic        fetch_valid_i;
  logic [63:0] fetch_addr_i;
  logic        out_valid_o, hit_o, fetch_fail_o;
  logic [55:0] real_addr_o;
  logic        install_i;
  logic [63:0] install_addr_i, install_pte_i;
  logic        inval_i;
  logic [63:0] inval_addr_i;
  logic [1:0]  inval_scope_i;
  logic [2:0]  inval_psize_i;
  logic        seginv_i;
  logic [2:0]  seginv_hint_i;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  itlb_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .redirect_i(redirect_i), .redirect_virt_i(redirect_virt_i), .redirect_priv_i(redirect_priv_i),
    .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
    .out_valid_o(out_valid_o), .hit_o(hit_o), .fetch_fail_o(fetch_fail_o), .real_addr_o(real_addr_o),
    .install_i(install_i), .install_addr_i(install_addr_i), .install_pte_i(install_pte_i),
    .inval_i(inval_i), .inval_addr_i(inval_addr_i), .inval_scope_i(inval_scope_i),
    .inval_psize_i(inval_psize_i), .seginv_i(seginv_i), .seginv_hint_i(seginv_hint_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // PTE encodings used below: bit 0 execute, bit 3 privileged, bit 8 referenced, [55:12] page
  localparam logic [63:0] EA_A  = 64'h0000_0000_0040_3000;  // slot 0x13
  localparam logic [63:0] PTE_A = 64'h0000_0000_00AB_C101;
  localparam logic [63:0] EA_B  = 64'h0000_0000_0000_5000;  // slot 0x05
  localparam logic [63:0] PTE_B = 64'h0000_0000_0123_4109;  // privileged page

  typedef struct packed {
    logic [63:0] ea;
    logic        priv;
    logic        hit;
    logic        fail;
    logic [55:0] ra;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0040_3ABC, 1'b0, 1'b1, 1'b0, 56'h00_0000_00AB_CABC},
    '{64'h0000_0000_0040_3000, 1'b1, 1'b1, 1'b0, 56'h00_0000_00AB_C000},
    '{64'h0000_0000_0000_5FF0, 1'b0, 1'b1, 1'b1, 56'h00_0000_0123_4FF0},
    '{64'h0000_0000_0000_5FF0, 1'b1, 1'b1, 1'b0, 56'h00_0000_0123_4FF0},
    '{64'h0000_0000_0000_7000, 1'b0, 1'b0, 1'b1, 56'h0},
    '{64'h0000_0001_0040_3000, 1'b0, 1'b0, 1'b1, 56'h0},
    '{64'h0000_0000_0001_3000, 1'b0, 1'b0, 1'b1, 56'h0},
    '{64'h0000_0000_1300_0000, 1'b0, 1'b0, 1'b1, 56'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    redirect_i = 0; redirect_virt_i = 0; redirect_priv_i = 0;
    fetch_valid_i = 0; fetch_addr_i = '0;
    install_i = 0; install_addr_i = '0; install_pte_i = '0;
    inval_i = 0; inval_addr_i = '0; inval_scope_i = '0; inval_psize_i = '0;
    seginv_i = 0; seginv_hint_i = '0;
  endtask

  // starts and ends at a falling edge; outputs are sampled one edge later
  task automatic fetch(input logic [63:0] ea, input logic redir, input logic virt, input logic priv);
    redirect_i = redir; redirect_virt_i = virt; redirect_priv_i = priv;
    fetch_valid_i = 1; fetch_addr_i = ea;
    @(negedge clk);
    redirect_i = 0; fetch_valid_i = 0;
  endtask

  task automatic install(input logic [63:0] ea, input logic [63:0] pte);
    install_i = 1; install_addr_i = ea; install_pte_i = pte;
    @(negedge clk);
    install_i = 0;
  endtask

  task automatic inval(input logic [63:0] ea, input logic [1:0] scope, input logic [2:0] psize);
    inval_i = 1; inval_addr_i = ea; inval_scope_i = scope; inval_psize_i = psize;
    @(negedge clk);
    inval_i = 0; inval_scope_i = '0; inval_psize_i = '0;
  endtask

  task automatic seginv(input logic [2:0] hint);
    seginv_i = 1; seginv_hint_i = hint;
    @(negedge clk);
    seginv_i = 0;
  endtask

  task automatic expect_xl(input string req, input logic [63:0] ea, input logic priv,
                           input logic hit, input logic fail);
    fetch(ea, 1'b1, 1'b1, priv);
    chk(req, {63'd0, out_valid_o}, 64'd1);
    chk(req, {63'd0, hit_o}, {63'd0, hit});
    chk(req, {63'd0, fetch_fail_o}, {63'd0, fail});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 out_valid", {63'd0, out_valid_o}, 64'd0);
    fetch(64'h0000_0000_0040_3000, 1'b0, 1'b0, 1'b0);
    chk("R1 real mode after reset", {63'd0, hit_o}, 64'd1);
    expect_xl("R1 empty table", EA_A, 1'b1, 1'b0, 1'b1);

    // populate two slots, then walk the table
    install(EA_A, PTE_A);
    install(EA_B, PTE_B);
    for (int v = 0; v < NV; v++) begin
      fetch(VECS[v].ea, 1'b1, 1'b1, VECS[v].priv);
      chk("R2/R4/R7/R8 valid", {63'd0, out_valid_o}, 64'd1);
      chk("R2/R4/R7/R8 hit", {63'd0, hit_o}, {63'd0, VECS[v].hit});
      chk("R2/R4/R7/R8 fail", {63'd0, fetch_fail_o}, {63'd0, VECS[v].fail});
      if (VECS[v].hit && !VECS[v].fail)
        chk("R4 real address", {8'd0, real_addr_o}, {8'd0, VECS[v].ra});
    end

    // R12: no fetch
    @(negedge clk);
    chk("R12 valid", {63'd0, out_valid_o}, 64'd0);
    chk("R12 hit", {63'd0, hit_o}, 64'd0);
    chk("R12 fail", {63'd0, fetch_fail_o}, 64'd0);

    // R10: modes held between redirects
    expect_xl("R10 set user", EA_B, 1'b0, 1'b1, 1'b1);
    fetch(EA_B, 1'b0, 1'b0, 1'b1);
    chk("R10 mode held", {63'd0, fetch_fail_o}, 64'd1);
    fetch(64'h0000_0000_0000_7000, 1'b0, 1'b0, 1'b1);
    chk("R10 still translating", {63'd0, hit_o}, 64'd0);

    // R11: real mode pass-through
    fetch(64'h0000_00AB_1234_5678, 1'b1, 1'b0, 1'b0);
    chk("R11 hit", {63'd0, hit_o}, 64'd1);
    chk("R11 fail", {63'd0, fetch_fail_o}, 64'd0);
    chk("R11 address", {8'd0, real_addr_o}, 64'h0000_00AB_1234_5678);

    // R3: replacement within slot 0x13
    install(64'h0000_0000_0001_3000, 64'h0000_0000_0077_7101);
    expect_xl("R3 new occupant", 64'h0000_0000_0001_3000, 1'b0, 1'b1, 1'b0);
    chk("R3 new address", {8'd0, real_addr_o}, 64'h0000_0000_0077_7000);
    expect_xl("R3 old occupant gone", EA_A, 1'b0, 1'b0, 1'b1);

    // R5: untagged single invalidate through an aliasing address
    inval(EA_A, 2'd0, 3'd0);
    expect_xl("R5 slot cleared", 64'h0000_0000_0001_3000, 1'b0, 1'b0, 1'b1);
    expect_xl("R5 other slot kept", EA_B, 1'b1, 1'b1, 1'b0);

    // R6: each flush trigger
    inval(64'h0, 2'd1, 3'd0);
    expect_xl("R6 scope flush", EA_B, 1'b1, 1'b0, 1'b1);
    install(EA_B, PTE_B);
    inval(64'h0, 2'd0, 3'd2);
    expect_xl("R6 page-size flush", EA_B, 1'b1, 1'b0, 1'b1);
    install(EA_B, PTE_B);
    seginv(3'd3);
    expect_xl("R6 other hint ignored", EA_B, 1'b1, 1'b1, 1'b0);
    seginv(3'd7);
    expect_xl("R6 hint 7 flush", EA_B, 1'b1, 1'b0, 1'b1);

    // R9: install filter
    install(64'h0000_0000_0000_7000, 64'h0000_0000_0055_5001);
    expect_xl("R9 unreferenced dropped", 64'h0000_0000_0000_7000, 1'b0, 1'b0, 1'b1);
    install(64'h0000_0000_0000_7000, 64'h0000_0000_0055_5100);
    expect_xl("R9 non-exec dropped", 64'h0000_0000_0000_7000, 1'b0, 1'b0, 1'b1);

    // R13: install concurrent with an invalidate of another slot
    install_i = 1; install_addr_i = 64'h0000_0000_0000_7000; install_pte_i = 64'h0000_0000_0055_5101;
    inval_i = 1; inval_addr_i = 64'h0;
    @(negedge clk);
    install_i = 0; inval_i = 0;
    expect_xl("R13 install dropped", 64'h0000_0000_0000_7000, 1'b0, 1'b0, 1'b1);

    install(64'h0000_0000_0000_7000, 64'h0000_0000_0055_5101);
    expect_xl("R9 good install", 64'h0000_0000_0000_7000, 1'b0, 1'b1, 1'b0);
    chk("R9 address", {8'd0, real_addr_o}, 64'h0000_0000_0055_5000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule